// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs a single conversion on a four-input general-purpose ADC inside a power-management device. A request names one of four inputs: battery voltage (0), die temperature (1), battery thermistor (2) or system temperature (3). The block then steps the ADC control word through a fixed order. For the thermistor input only, the external bias is switched on first and given a long lead time. Next the ADC is enabled with the channel field written. After a guaranteed gap, start is raised. The block then waits for the converter's done pulse, bounded by a timeout.

On every exit path, success or timeout, a one-cycle teardown clears start, enable and bias together. In that same cycle the block reports either a valid result or a timeout flag. While the request is in progress, the byte address of the selected input's result register is presented. Every delay is a cycle count derived from the clock frequency and a time in microseconds, so a bench can shrink them through parameters.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `ctrl_o`, `busy_o`, `res_valid_o`, `timeout_o` and `res_o` are all zero.
- R2: Control word layout: bit 0 is start, bits 2:1 carry the channel, bit 5 is ADC enable, bit 6 is thermistor bias. Bits 3, 4 and 7 are always zero, and the channel field is zero whenever enable is low.
- R3: Enable, together with the channel field, rises without start. Start rises exactly GAP cycles after enable first went high, and enable stays high throughout that gap.
- R4: For channel 2 only, bias alone (control word 0x40) is driven for BIAS cycles before enable rises, and bias stays on through enable and start. Other channels never raise bias.
- R5: A done pulse while start is high captures the low 10 bits of the 16-bit `adc_data_i` (bits 15:10 are dropped) into `res_o`. The channel goes to `res_ch_o`, and `res_valid_o` pulses for one cycle on the next edge. A done pulse in the last waiting cycle still counts as a success.
- R6: If no done pulse arrives in the TIMEOUT cycles that start is high, `timeout_o` pulses for one cycle and `res_o` keeps its previous value.
- R7: In the cycle where `res_valid_o` or `timeout_o` is high, the control word is all zero, bias included.
- R8: While busy, `rd_addr_o` equals 0x54 + 2 × channel.
- R9: `busy_o` rises the cycle after an accepted request and falls one cycle after the teardown cycle. A request made while busy is ignored, and the channel in progress does not change.
- R10: A done pulse outside the waiting phase is ignored: no valid pulse is produced and `res_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Conversion request, accepted when idle |
| req_ch_i | input | 2 | Channel of the request |
| adc_done_i | input | 1 | Conversion-done pulse from the ADC |
| adc_data_i | input | 16 | Result word, high byte first |
| ctrl_o | output | 8 | ADC control word |
| rd_addr_o | output | 8 | Byte address of the selected result register |
| busy_o | output | 1 | Sequence in progress |
| res_o | output | 10 | Last captured result |
| res_ch_o | output | 2 | Channel of the last captured result |
| res_valid_o | output | 1 | One-cycle pulse on a new result |
| timeout_o | output | 1 | One-cycle pulse on conversion timeout |

## Verification
On every cycle, the assertions check several properties. Start never rises in the same cycle as enable, and the counted enable and bias lead times are met at the edge where start or enable rises. Bias appears only when the channel-2 address is selected, and the control word is fully cleared whenever a result or timeout is reported. A result is reported only after start was high. A few behaviours can only be shown by the bench's scenarios: the captured value and its dropped upper bits, timeouts on a plain channel and on the thermistor channel, the success boundary in the last waiting cycle, and stray requests and done pulses made during enable or idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BIAS,
    S_ENA,
    S_WAIT,
    S_TEAR
  } seq_state_e;

  localparam int CTRL_W   = 8;
  localparam int START_B  = 0;
  localparam int CH_LO    = 1;
  localparam int EN_B     = 5;
  localparam int BIAS_B   = 6;

  // time in us to cycles, never below one cycle
  function automatic longint us_to_cyc(longint clk_hz, longint us);
    longint c;
    c = (clk_hz * us) / 64'd1000000;
    return (c < 1) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  p_load_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int        CH_W     = 2,
  parameter int        CNT_W    = 8,
  parameter int        BIAS_CH  = 2,
  parameter logic [CNT_W-1:0] GAP_V  = CNT_W'(8),
  parameter logic [CNT_W-1:0] BIAS_V = CNT_W'(20),
  parameter logic [CNT_W-1:0] TO_V   = CNT_W'(60)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic              done_i,
  input  logic              expired_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              busy_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              capture_o,
  output logic              timeout_o
);

  seq_state_e      st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            to_q, to_d;
  logic            bias_ch;

  assign bias_ch = (ch_q == CH_W'(BIAS_CH));

  always_comb begin
    st_d       = st_q;
    ch_d       = ch_q;
    load_o     = 1'b0;
    load_val_o = GAP_V;
    capture_o  = 1'b0;
    to_d       = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_i) begin
        ch_d   = req_ch_i;
        load_o = 1'b1;
        if (req_ch_i == CH_W'(BIAS_CH)) begin
          st_d       = S_BIAS;
          load_val_o = BIAS_V;
        end else begin
          st_d = S_ENA;
        end
      end
      S_BIAS: if (expired_i) begin
        st_d   = S_ENA;
        load_o = 1'b1;
      end
      S_ENA: if (expired_i) begin
        st_d       = S_WAIT;
        load_o     = 1'b1;
        load_val_o = TO_V;
      end
      S_WAIT: begin
        if (done_i) begin
          st_d      = S_TEAR;
          capture_o = 1'b1;
        end else if (expired_i) begin
          st_d = S_TEAR;
          to_d = 1'b1;
        end
      end
      S_TEAR:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      ch_q <= '0;
      to_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
      to_q <= to_d;
    end
  end

  always_comb begin
    ctrl_o = '0;
    if (st_q == S_ENA || st_q == S_WAIT) begin
      ctrl_o[EN_B]            = 1'b1;
      ctrl_o[CH_LO +: CH_W]   = ch_q;
    end
    if (st_q == S_WAIT) ctrl_o[START_B] = 1'b1;
    if ((st_q == S_BIAS || st_q == S_ENA || st_q == S_WAIT) && bias_ch)
      ctrl_o[BIAS_B] = 1'b1;
  end

  assign busy_o    = (st_q != S_IDLE);
  assign ch_o      = ch_q;
  assign timeout_o = to_q;

  // lead-time counters observed by the checks below
  logic [CNT_W-1:0] en_run_q, bias_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_run_q   <= '0;
      bias_run_q <= '0;
    end else begin
      en_run_q   <= !ctrl_o[EN_B] ? '0 :
                    (&en_run_q) ? en_run_q : en_run_q + CNT_W'(1);
      bias_run_q <= !ctrl_o[BIAS_B] ? '0 :
                    (&bias_run_q) ? bias_run_q : bias_run_q + CNT_W'(1);
    end
  end

  p_en_before_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[START_B]) |-> $past(ctrl_o[EN_B]));

  p_gap_met_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[START_B]) |-> (en_run_q >= GAP_V));

  p_bias_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_o[EN_B]) && ctrl_o[BIAS_B]) |-> (bias_run_q >= BIAS_V));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ctrl_o == '0));

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int          CH_W      = 2,
  parameter int          DATA_W    = 16,
  parameter int          RES_W     = 10,
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [RES_W-1:0]  res_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o
);

  logic [DATA_W-RES_W-1:0] unused_hi;
  assign unused_hi = data_i[DATA_W-1:RES_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_ch_o    <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= capture_i;
      if (capture_i) begin
        res_o    <= data_i[RES_W-1:0];
        res_ch_o <= ch_i;
      end
    end
  end

  // two bytes per channel, high byte at the lower address
  assign rd_addr_o = DATA_BASE + ADDR_W'({ch_i, 1'b0});

  p_res_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i) |-> $stable(res_o));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint GAP_US     = 50,
  parameter longint BIAS_US    = 35_000,
  parameter longint TIMEOUT_US = 5_000_000,
  parameter int     CH_W       = 2,
  parameter int     DATA_W     = 16,
  parameter int     RES_W      = 10,
  parameter int     ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h54,
  parameter int     BIAS_CH    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  res_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic              res_valid_o,
  output logic              timeout_o
);

  localparam longint GAP_CYC  = us_to_cyc(CLK_HZ, GAP_US);
  localparam longint BIAS_CYC = us_to_cyc(CLK_HZ, BIAS_US);
  localparam longint TO_CYC   = us_to_cyc(CLK_HZ, TIMEOUT_US);
  localparam longint MAX_A    = (GAP_CYC > BIAS_CYC) ? GAP_CYC : BIAS_CYC;
  localparam longint MAX_CYC  = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
  localparam int     CNT_W    = $clog2(MAX_CYC + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             capture;
  logic [CH_W-1:0]  ch;

  adc_seq_timer #(.W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .val_i    (load_val),
    .expired_o(expired)
  );

  adc_seq_fsm #(
    .CH_W   (CH_W),
    .CNT_W  (CNT_W),
    .BIAS_CH(BIAS_CH),
    .GAP_V  (CNT_W'(GAP_CYC)),
    .BIAS_V (CNT_W'(BIAS_CYC)),
    .TO_V   (CNT_W'(TO_CYC))
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .req_ch_i  (req_ch_i),
    .done_i    (adc_done_i),
    .expired_i (expired),
    .load_o    (load),
    .load_val_o(load_val),
    .ctrl_o    (ctrl_o),
    .busy_o    (busy_o),
    .ch_o      (ch),
    .capture_o (capture),
    .timeout_o (timeout_o)
  );

  adc_seq_result #(
    .CH_W     (CH_W),
    .DATA_W   (DATA_W),
    .RES_W    (RES_W),
    .ADDR_W   (ADDR_W),
    .DATA_BASE(DATA_BASE)
  ) u_result (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .data_i     (adc_data_i),
    .ch_i       (ch),
    .res_o      (res_o),
    .res_ch_o   (res_ch_o),
    .res_valid_o(res_valid_o),
    .rd_addr_o  (rd_addr_o)
  );

  p_teardown_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || timeout_o) |-> (ctrl_o[BIAS_B] == 1'b0 && ctrl_o[EN_B] == 1'b0
                                    && ctrl_o[START_B] == 1'b0));

  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && timeout_o));

  p_bias_only_ch2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[BIAS_B] |-> (rd_addr_o == DATA_BASE + ADDR_W'(2 * BIAS_CH)));

  p_done_in_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(ctrl_o[START_B]));

  p_ch_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  p_spare_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3] == 1'b0 && ctrl_o[4] == 1'b0 && ctrl_o[7] == 1'b0));

endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

  localparam int GAP  = 8;
  localparam int BIAS = 20;
  localparam int TO   = 60;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  req_ch_i = '0;
  logic        adc_done_i = 1'b0;
  logic [15:0] adc_data_i = '0;
  logic [7:0]  ctrl_o;
  logic [7:0]  rd_addr_o;
  logic        busy_o;
  logic [9:0]  res_o;
  logic [1:0]  res_ch_o;
  logic        res_valid_o;
  logic        timeout_o;

  always #5 clk_i = ~clk_i;

  adc_conv_seq #(
    .CLK_HZ    (1_000_000),
    .GAP_US    (GAP),
    .BIAS_US   (BIAS),
    .TIMEOUT_US(TO)
  ) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_ch_i   (req_ch_i),
    .adc_done_i (adc_done_i),
    .adc_data_i (adc_data_i),
    .ctrl_o     (ctrl_o),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .res_o      (res_o),
    .res_ch_o   (res_ch_o),
    .res_valid_o(res_valid_o),
    .timeout_o  (timeout_o)
  );

  typedef struct {
    logic [1:0] ch;
    logic [9:0] res;
    bit         to;
  } exp_t;

  exp_t       sb_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         fin = 1'b0;
  logic [9:0] last_res = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] word(input logic [1:0] ch, input bit en,
                                      input bit st, input bit bias);
    return {1'b0, bias, en, 2'b00, (en ? ch : 2'b00), st};
  endfunction

  // monitor: compares each reported outcome against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && (res_valid_o || timeout_o)) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected outcome", {30'd0, res_valid_o, timeout_o}, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.to) begin
          chk(timeout_o && !res_valid_o, "R6 timeout flag", {30'd0, res_valid_o, timeout_o}, 32'd1);
          chk(res_o == e.res, "R6 result kept", res_o, e.res);
        end else begin
          chk(res_valid_o && !timeout_o, "R5 valid flag", {30'd0, res_valid_o, timeout_o}, 32'd2);
          chk(res_o == e.res, "R5 result", res_o, e.res);
          chk(res_ch_o == e.ch, "R5 channel", res_ch_o, e.ch);
        end
      end
    end
  end

  // driver: delay<0 means no done pulse (timeout)
  task automatic run_conv(input logic [1:0] ch, input logic [15:0] data,
                          input int delay, input bit inject);
    exp_t e;
    bit   b;
    b    = (ch == 2'd2);
    e.ch = ch;
    e.to = (delay < 0);
    e.res = e.to ? last_res : data[9:0];
    sb_q.push_back(e);
    if (!e.to) last_res = data[9:0];

    @(negedge clk_i);
    req_i = 1'b1; req_ch_i = ch;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    chk(rd_addr_o == 8'h54 + 8'(2 * ch), "R8 address", rd_addr_o, 8'h54 + 8'(2 * ch));
    if (b) begin
      chk(ctrl_o == word(ch, 0, 0, 1), "R4 bias first", ctrl_o, word(ch, 0, 0, 1));
      repeat (BIAS - 1) @(negedge clk_i);
      chk(ctrl_o == word(ch, 0, 0, 1), "R4 bias lead", ctrl_o, word(ch, 0, 0, 1));
      @(negedge clk_i);
    end
    chk(ctrl_o == word(ch, 1, 0, b), "R2 R3 enable word", ctrl_o, word(ch, 1, 0, b));
    if (inject) begin
      req_i = 1'b1; req_ch_i = ~ch;
      adc_done_i = 1'b1; adc_data_i = 16'hFFFF;
    end
    for (int k = 1; k < GAP; k++) begin
      @(negedge clk_i);
      if (k == 1 && inject) begin
        req_i = 1'b0; adc_done_i = 1'b0;
        chk(rd_addr_o == 8'h54 + 8'(2 * ch), "R9 stray request ignored", rd_addr_o,
            8'h54 + 8'(2 * ch));
        chk(res_valid_o == 1'b0, "R10 stray done ignored", res_valid_o, 0);
      end
    end
    chk(ctrl_o[0] == 1'b0, "R3 no start before gap", ctrl_o, word(ch, 1, 0, b));
    @(negedge clk_i);
    chk(ctrl_o == word(ch, 1, 1, b), "R3 start after gap", ctrl_o, word(ch, 1, 1, b));
    if (delay >= 0) begin
      repeat (delay) @(negedge clk_i);
      adc_done_i = 1'b1; adc_data_i = data;
      @(negedge clk_i);
      adc_done_i = 1'b0; adc_data_i = '0;
    end else begin
      repeat (TO - 1) @(negedge clk_i);
      chk(timeout_o == 1'b0 && ctrl_o[0], "R6 still waiting", {timeout_o, ctrl_o}, {1'b0, word(ch, 1, 1, b)});
      @(negedge clk_i);
    end
    chk(ctrl_o == 8'h00, "R7 teardown clears", ctrl_o, 0);
    chk(busy_o == 1'b1, "R9 busy in teardown", busy_o, 1);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R9 idle after teardown", busy_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ctrl_o == 0 && !busy_o && !res_valid_o && !timeout_o && res_o == 0,
        "R1 reset state", {ctrl_o, busy_o, res_valid_o, timeout_o, res_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ctrl_o == 0 && !busy_o, "R1 idle after reset", {ctrl_o, busy_o}, 0);

    run_conv(2'd0, 16'hFC5A, 3, 1'b0);       // R5 upper bits dropped
    run_conv(2'd1, 16'h0155, 0, 1'b1);       // R9 R10 stray inputs in enable phase
    run_conv(2'd2, 16'h03FF, TO - 1, 1'b0);  // R4 bias, R5 last-cycle boundary
    run_conv(2'd3, 16'h0000, -1, 1'b0);      // R6 timeout

    // R10: done while idle
    @(negedge clk_i);
    adc_done_i = 1'b1; adc_data_i = 16'h0123;
    @(negedge clk_i);
    adc_done_i = 1'b0;
    @(negedge clk_i);
    chk(res_o == last_res && !res_valid_o, "R10 idle done ignored", res_o, last_res);

    run_conv(2'd2, 16'h0000, -1, 1'b0);      // R7 bias off on timeout
    run_conv(2'd3, 16'h8201, 5, 1'b0);

    repeat (3) @(negedge clk_i);
    chk(sb_q.size() == 0, "R5 all outcomes seen", sb_q.size(), 0);
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule